// File: doc/BRIEF.md
# Grounded-Input Offset Calibration Engine

This engine finds the offset trim code of an analog-to-digital converter whose input is tied to ground. It runs a binary search over a 4096-code trim range and drives each trial code to the converter. After every conversion it narrows the bounds on whether the converter returned zero. It runs ten such searches back to back, drops the smallest and largest result, and averages the other eight. The average is rounded to the nearest code, and the result is applied to the converter.

The finished code is kept in a small table with one entry for each pair of converter unit and attenuation setting. A later request for a pair whose entry is nonzero returns the stored code at once, without any conversion. The force input overrides this and runs a fresh calibration. During a calibration the engine presents the requested unit and attenuation to the converter. With every channel disconnected, this attenuation is the one applied through the channel-0 setting.

Top module: `offset_cal_engine`

## Requirements
- R1: After reset, `busy`, `cal_done` and `conv_start` are low, and `cal_code` and `conv_code` are zero.
- R2: Each search starts with bounds low=0 and high=4096, and its first trial code is 2048. When a conversion result is zero, the high bound takes the trial code; otherwise the low bound does. The next trial is the midpoint of the bounds, rounded down. For a grounded offset below 2048, the second trial is therefore 1024.
- R3: Once high minus low equals 1, the midpoint is measured, then the trial code is incremented by one and measured once more. That incremented code is the search result. With a converter that returns zero exactly when code > O, a search therefore yields O+1, including 4096 for O=4095 and 1 for O=0.
- R4: A calibration runs 10 searches over the full range, which is 14 conversions per search and 140 conversions in total.
- R5: The final code is (S − min − max) / 8, where S is the sum of the 10 search results and min and max are the smallest and largest of them.
- R6: The quotient is raised by one when the remainder of that division is 4 or more, and is truncated otherwise.
- R7: When a calibration finishes, the final code appears on both `cal_code` and `conv_code`. `cal_done` pulses high for one cycle while `busy` is low.
- R8: A request without force, for a unit and attenuation pair whose stored code is nonzero, causes no conversion. `cal_done` rises on the clock edge that samples the request, and `cal_code` carries the stored code.
- R9: A request with `cal_force` high always runs a full calibration and replaces the stored code.
- R10: While `busy` is high, `conv_unit` and `conv_atten` hold the unit and attenuation that were sampled with the request.
- R11: `conv_start` is a one-cycle pulse. No new `conv_start` is issued until `conv_done` has been seen for the previous conversion, whatever the converter latency.
- R12: Stored codes are kept separately for each unit and attenuation pair. A pair that has never been calibrated runs a full calibration even when other pairs hold codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Request a calibration; sampled while idle |
| cal_force | input | 1 | Ignore any stored code and recalibrate |
| cal_unit | input | UNIT_W | Converter unit index |
| cal_atten | input | ATTEN_W | Attenuation index |
| conv_code | output | CODE_W | Trim code driven to the converter |
| conv_start | output | 1 | One-cycle conversion start |
| conv_done | input | 1 | Conversion complete, with `conv_data` valid |
| conv_data | input | DATA_W | Conversion result |
| conv_unit | output | UNIT_W | Unit being calibrated |
| conv_atten | output | ATTEN_W | Attenuation applied during calibration |
| busy | output | 1 | Calibration in progress |
| cal_code | output | CODE_W | Resulting or stored calibration code |
| cal_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the converter raises `conv_done` only after a `conv_start`, and only once per start. They also assume that requests arrive only while the engine is idle, so the sampled unit and attenuation cannot change mid-run. The converter model in the bench answers each start exactly once, after one to three cycles. The model returns zero whenever the trial code exceeds a hidden offset, and that offset is shifted by a fixed amount for each search. Requests are issued only after the previous `cal_done`.

// File: rtl/offset_cal_engine.sv
module offset_cal_engine #(
  parameter int CODE_W  = 13,
  parameter int DATA_W  = 12,
  parameter int SPAN    = 4096,
  parameter int REPEATS = 10,
  parameter int RND_THR = 4,
  parameter int UNITS   = 2,
  parameter int ATTENS  = 4,
  localparam int UNIT_W  = (UNITS  > 1) ? $clog2(UNITS)  : 1,
  localparam int ATTEN_W = (ATTENS > 1) ? $clog2(ATTENS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_req,
  input  logic               cal_force,
  input  logic [UNIT_W-1:0]  cal_unit,
  input  logic [ATTEN_W-1:0] cal_atten,
  output logic [CODE_W-1:0]  conv_code,
  output logic               conv_start,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic [UNIT_W-1:0]  conv_unit,
  output logic [ATTEN_W-1:0] conv_atten,
  output logic               busy,
  output logic [CODE_W-1:0]  cal_code,
  output logic               cal_done
);

  localparam int ENTRIES = UNITS * ATTENS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int REP_W   = $clog2(REPEATS);
  localparam int SUM_W   = $clog2(SPAN * REPEATS + 1);
  localparam int DIV     = REPEATS - 2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINISH} state_t;

  state_t             state;
  logic [CODE_W-1:0]  hi, lo, code;
  logic               last;
  logic [REP_W-1:0]   rep;
  logic [SUM_W-1:0]   sum;
  logic [CODE_W-1:0]  mn, mx;
  logic [UNIT_W-1:0]  unit_q;
  logic [ATTEN_W-1:0] atten_q;
  logic [CODE_W-1:0]  store [ENTRIES];

  logic [IDX_W-1:0]   idx_in, idx_q;
  logic               got_zero;
  logic [CODE_W-1:0]  nhi, nlo;
  logic [CODE_W:0]    msum;
  logic [SUM_W-1:0]   trim, quo, rmd;
  logic [CODE_W-1:0]  final_code;

  assign idx_in     = IDX_W'(cal_unit) * IDX_W'(ATTENS) + IDX_W'(cal_atten);
  assign idx_q      = IDX_W'(unit_q) * IDX_W'(ATTENS) + IDX_W'(atten_q);
  assign got_zero   = (conv_data == '0);
  assign nhi        = got_zero ? code : hi;
  assign nlo        = got_zero ? lo : code;
  assign msum       = {1'b0, nhi} + {1'b0, nlo};
  assign trim       = sum - SUM_W'(mn) - SUM_W'(mx);
  assign quo        = trim / SUM_W'(DIV);
  assign rmd        = trim % SUM_W'(DIV);
  assign final_code = CODE_W'(quo) + CODE_W'(rmd >= SUM_W'(RND_THR));

  assign conv_start = (state == S_ISSUE);
  assign busy       = (state != S_IDLE);
  assign conv_code  = code;
  assign conv_unit  = unit_q;
  assign conv_atten = atten_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hi       <= '0;
      lo       <= '0;
      code     <= '0;
      last     <= 1'b0;
      rep      <= '0;
      sum      <= '0;
      mn       <= '0;
      mx       <= '0;
      unit_q   <= '0;
      atten_q  <= '0;
      cal_code <= '0;
      cal_done <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) store[i] <= '0;
    end else begin
      cal_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cal_req) begin
            if (!cal_force && store[idx_in] != '0) begin
              cal_code <= store[idx_in];
              cal_done <= 1'b1;
            end else begin
              unit_q  <= cal_unit;
              atten_q <= cal_atten;
              rep     <= '0;
              sum     <= '0;
              hi      <= CODE_W'(SPAN);
              lo      <= '0;
              code    <= CODE_W'(SPAN / 2);
              last    <= 1'b0;
              state   <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (conv_done) begin
            if (last) begin
              sum <= sum + SUM_W'(code);
              if (rep == '0 || code < mn) mn <= code;
              if (rep == '0 || code > mx) mx <= code;
              if (rep == REP_W'(REPEATS - 1)) begin
                state <= S_FINISH;
              end else begin
                rep   <= rep + 1'b1;
                hi    <= CODE_W'(SPAN);
                lo    <= '0;
                code  <= CODE_W'(SPAN / 2);
                last  <= 1'b0;
                state <= S_ISSUE;
              end
            end else if (hi - lo > CODE_W'(1)) begin
              hi    <= nhi;
              lo    <= nlo;
              code  <= msum[CODE_W:1];
              state <= S_ISSUE;
            end else begin
              code  <= code + 1'b1;
              last  <= 1'b1;
              state <= S_ISSUE;
            end
          end
        end
        S_FINISH: begin
          cal_code     <= final_code;
          code         <= final_code;
          store[idx_q] <= final_code;
          cal_done     <= 1'b1;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_wait_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !conv_done) |=> !conv_start);

  assert_bounds_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (hi > lo));

  assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_code <= CODE_W'(SPAN)));

  assert_all_searches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FINISH) |-> (rep == REP_W'(REPEATS - 1)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !busy);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(conv_atten) && $stable(conv_unit)));

endmodule

// File: tb/offset_cal_engine_test.sv
`timescale 1ns/1ps
module offset_cal_engine_test;
  localparam int CONV_PER_SEARCH = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_req = 1'b0, cal_force = 1'b0;
  logic [0:0]  cal_unit = '0;
  logic [1:0]  cal_atten = '0;
  logic [12:0] conv_code, cal_code;
  logic        conv_start, conv_done, busy, cal_done;
  logic [11:0] conv_data;
  logic [0:0]  conv_unit;
  logic [1:0]  conv_atten;

  int checks = 0, errors = 0;
  int base_off = 0;
  int jit [10];
  int conv_count = 0, first_code = -1, second_code = -1;
  int overlap = 0, cfg_bad = 0;
  int stored00 = 0;

  always #2 clk = ~clk;

  offset_cal_engine uut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_force(cal_force),
    .cal_unit(cal_unit), .cal_atten(cal_atten), .conv_code(conv_code),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .conv_unit(conv_unit), .conv_atten(conv_atten), .busy(busy),
    .cal_code(cal_code), .cal_done(cal_done)
  );

  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (rst_n && conv_start) begin
        automatic int sidx = conv_count / CONV_PER_SEARCH;
        automatic int off;
        automatic int lat = 1 + (conv_count % 3);
        if (sidx > 9) sidx = 9;
        off = base_off + jit[sidx];
        if (conv_count == 0) first_code = int'(conv_code);
        if (conv_count == 1) second_code = int'(conv_code);
        if (conv_unit != cal_unit || conv_atten != cal_atten) cfg_bad++;
        conv_data = (int'(conv_code) > off) ? 12'd0 : 12'd1;
        conv_count++;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (conv_start) overlap++;
        end
        conv_done = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_search(input int o);
    int hi = 4096, lo = 0, chk = 2048, d;
    d = (chk > o) ? 0 : 1;
    while (hi - lo > 1) begin
      if (d == 0) hi = chk; else lo = chk;
      chk = (hi + lo) / 2;
      d = (chk > o) ? 0 : 1;
      if (hi - lo == 1) begin
        chk = chk + 1;
        d = (chk > o) ? 0 : 1;
      end
    end
    return chk;
  endfunction

  function automatic int ref_cal(input int b);
    int s = 0, mn = 99999, mx = -1, t, r;
    for (int i = 0; i < 10; i++) begin
      r = ref_search(b + jit[i]);
      s += r;
      if (r < mn) mn = r;
      if (r > mx) mx = r;
    end
    t = s - mn - mx;
    return ((t % 8) >= 4) ? t / 8 + 1 : t / 8;
  endfunction

  task automatic set_jit(input int j0, j1, j2, j3, j4, j5, j6, j7, j8, j9);
    jit[0] = j0; jit[1] = j1; jit[2] = j2; jit[3] = j3; jit[4] = j4;
    jit[5] = j5; jit[6] = j6; jit[7] = j7; jit[8] = j8; jit[9] = j9;
  endtask

  task automatic run_cal(input int u, input int a, input bit f, output int cycles);
    @(negedge clk);
    cal_unit = u[0:0];
    cal_atten = a[1:0];
    cal_force = f;
    conv_count = 0;
    first_code = -1;
    second_code = -1;
    overlap = 0;
    cfg_bad = 0;
    cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    cal_force = 1'b0;
    cycles = 1;
    while (!cal_done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic test_reset();
    check(!busy && !cal_done && !conv_start, "R1 control low", int'(busy), 0);
    check(cal_code == 0 && conv_code == 0, "R1 codes zero", int'(cal_code), 0);
  endtask

  task automatic test_main();
    int cyc, exp;
    base_off = 1000;
    set_jit(0, 3, -2, 5, 1, -4, 2, 0, 7, -1);
    exp = ref_cal(1000);
    run_cal(0, 0, 1'b0, cyc);
    check(first_code == 2048, "R2 first trial", first_code, 2048);
    check(second_code == 1024, "R2 second trial", second_code, 1024);
    check(conv_count == 140, "R4 conversion count", conv_count, 140);
    check(int'(cal_code) == exp, "R5 trimmed average", int'(cal_code), exp);
    check(int'(conv_code) == exp, "R7 code applied", int'(conv_code), exp);
    check(cal_done && !busy, "R7 done pulse idle", int'(busy), 0);
    @(negedge clk);
    check(!cal_done, "R7 done one cycle", int'(cal_done), 0);
    check(cfg_bad == 0, "R10 unit/atten held", cfg_bad, 0);
    check(overlap == 0, "R11 no start before done", overlap, 0);
    stored00 = exp;
  endtask

  task automatic test_single_result();
    int cyc;
    base_off = 1234;
    set_jit(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_cal(0, 1, 1'b0, cyc);
    check(cal_code == 13'd1235, "R3 result offset+1", int'(cal_code), 1235);
    base_off = 4095;
    run_cal(0, 2, 1'b0, cyc);
    check(cal_code == 13'd4096, "R3 top edge", int'(cal_code), 4096);
    base_off = 0;
    run_cal(0, 3, 1'b0, cyc);
    check(cal_code == 13'd1, "R3 bottom edge", int'(cal_code), 1);
  endtask

  task automatic test_rounding();
    int cyc, exp;
    base_off = 500;
    set_jit(0, 0, 0, 0, 0, 0, 0, 4, -9, 20);
    exp = ref_cal(500);
    run_cal(1, 2, 1'b0, cyc);
    check(cal_code == 13'd502 && exp == 502, "R6 remainder 4 rounds up", int'(cal_code), 502);
    set_jit(0, 0, 0, 3, 0, 0, 0, 0, -9, 20);
    exp = ref_cal(500);
    run_cal(1, 3, 1'b0, cyc);
    check(cal_code == 13'd501 && exp == 501, "R6 remainder 3 truncates", int'(cal_code), 501);
  endtask

  task automatic test_cache_hit();
    int cyc;
    base_off = 3000;
    run_cal(0, 0, 1'b0, cyc);
    check(conv_count == 0, "R8 no conversions on hit", conv_count, 0);
    check(cyc == 1, "R8 immediate done", cyc, 1);
    check(int'(cal_code) == stored00, "R8 stored code", int'(cal_code), stored00);
  endtask

  task automatic test_force();
    int cyc;
    base_off = 2000;
    set_jit(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_cal(0, 0, 1'b1, cyc);
    check(conv_count == 140, "R9 forced full run", conv_count, 140);
    check(cal_code == 13'd2001, "R9 forced result", int'(cal_code), 2001);
    run_cal(0, 0, 1'b0, cyc);
    check(cal_code == 13'd2001 && conv_count == 0, "R9 store replaced", int'(cal_code), 2001);
  endtask

  task automatic test_separate_entries();
    int cyc;
    base_off = 700;
    set_jit(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_cal(1, 0, 1'b0, cyc);
    check(conv_count == 140, "R12 new pair runs", conv_count, 140);
    check(cal_code == 13'd701, "R12 new pair result", int'(cal_code), 701);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) jit[i] = 0;
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_main();
    test_single_result();
    test_rounding();
    test_cache_hit();
    test_force();
    test_separate_entries();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule